// File: doc/BRIEF.md
# Partitionable Direct-Mapped Second-Level Cache Controller

This controller sits between a processor's request port and a slower main-memory port, and it steers a fast, asynchronously read local SRAM. The controller keeps the tags and valid bits itself. For each processor access it decides whether the SRAM answers or the access goes out to main memory. Every processor write goes through to main memory. A write also updates the SRAM copy when the line is present.

A split setting divides the SRAM into two halves. One half stays a direct-mapped cache. The other half becomes a fixed 32-word window of plain local memory at a configurable base. That window can be made read-only, for example to hold a shadowed ROM image, and then it accepts writes only while a load-enable input is high. A snoop input reports the lines written by other bus masters, and a flush input drops every cached line in one cycle.

Top module: `l2_split_ctrl`

## Requirements
- R1: Addresses are word addresses. The word-in-line offset is addr[1:0]. With the split setting off, the line index is addr[5:2]. The tag is addr[15:5]. A cacheable read that hits completes in its first cycle with the SRAM data and causes no main-memory transfer.
- R2: A cacheable read miss keeps cpu_wait high for 1 + (main-memory latency) cycles. It fetches the line as four single-word requests in wrapping order, starting with the requested word. That word is returned to the processor in the cycle it arrives.
- R3: Once all four words of a fill have arrived, the line becomes valid, and later reads of any of its words hit.
- R4: Every write outside the local window produces exactly one main-memory write. When the line is present, the write also updates the SRAM copy, so later hits return the new value.
- R5: A write miss allocates nothing. A later read of that address is a miss.
- R6: A snoop naming a cached line (snoop_line = addr[15:2]) invalidates that line. A snoop that names the line currently being filled prevents that line from becoming valid.
- R7: After reset, and after a one-cycle flush pulse, no line is valid.
- R8: With the split setting on, the cache uses the lower half of the SRAM and the line index is addr[4:2]. Addresses with addr[15:5] equal to lbase form a 32-word local window. Accesses to the window complete in one cycle, produce no main-memory transfer, and leave cached lines undisturbed.
- R9: While the read-only setting is on, writes to the local window are dropped unless shadow_load is high.
- R10: An access marked uncacheable bypasses the SRAM. Its read data comes from main memory, and its write does not change any cached copy.
- R11: A main-memory request, together with its address and direction, stays unchanged until it is acknowledged. Each acknowledge transfers one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_split | input | 1 | 1: half cache, half local window |
| cfg_lbase | input | AW-SAW+1 | Local window base (address bits 15:5) |
| cfg_lro | input | 1 | Local window read-only |
| shadow_load | input | 1 | Allows writes to a read-only window |
| flush | input | 1 | Invalidate all lines |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write |
| cpu_nc | input | 1 | Access is uncacheable |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| cpu_wait | output | 1 | Access not finished this cycle |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | SAW | SRAM word address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data (asynchronous) |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write |
| mem_addr | output | AW | Main-memory word address |
| mem_wdata | output | DW | Main-memory write data |
| mem_ack | input | 1 | Main-memory word transferred |
| mem_rdata | input | DW | Main-memory read data |
| snoop_valid | input | 1 | External write observed |
| snoop_line | input | AW-2 | Line address of the external write |

## Verification
Hits and local-window accesses are due in the very cycle the request is presented, with zero wait cycles. A miss, an uncacheable read or a write keeps the processor waiting for one decode cycle plus the memory latency. The remaining three fill words follow, each taking latency + 1 cycles. The bench's reference model predicts the data, the exact wait count and the number of main-memory words for every access. The bench samples one time unit before each rising edge and counts memory words over a settle window long enough for a fill to finish. A snoop is injected in the cycle right after the critical word, so it lands inside a running fill.

// File: rtl/l2_split_ctrl.sv
`timescale 1ns/1ps
module l2_split_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int SAW = 6,
  parameter int OW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_split,
  input  logic [AW-SAW:0]  cfg_lbase,
  input  logic             cfg_lro,
  input  logic             shadow_load,
  input  logic             flush,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             cpu_nc,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_wait,
  output logic             sram_we,
  output logic [SAW-1:0]   sram_addr,
  output logic [DW-1:0]    sram_wdata,
  input  logic [DW-1:0]    sram_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             snoop_valid,
  input  logic [AW-OW-1:0] snoop_line
);
  localparam int IW    = SAW - OW;
  localparam int LINES = 1 << IW;
  localparam int TW    = AW - SAW + 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_MRD, S_MWR} st_t;

  st_t             st, nxt;
  logic [LINES-1:0] vld;
  logic [TW-1:0]    tags [LINES];
  logic [OW-1:0]    cnt;
  logic [AW-1:0]    fa;
  logic             kill;

  logic [IW-1:0] c_idx, f_idx, s_idx;
  logic [TW-1:0] c_tag, f_tag, s_tag;
  logic [OW-1:0] f_off;
  logic          c_hit, c_loc, c_lwok, s_hit, s_fill, f_last, f_done, miss_go;

  assign c_idx  = cfg_split ? {1'b0, cpu_addr[SAW-2:OW]} : cpu_addr[SAW-1:OW];
  assign c_tag  = cpu_addr[AW-1:SAW-1];
  assign c_hit  = vld[c_idx] && (tags[c_idx] == c_tag);
  assign c_loc  = cfg_split && (c_tag == cfg_lbase);
  assign c_lwok = !cfg_lro || shadow_load;

  assign f_idx  = cfg_split ? {1'b0, fa[SAW-2:OW]} : fa[SAW-1:OW];
  assign f_tag  = fa[AW-1:SAW-1];
  assign f_off  = fa[OW-1:0] + cnt;
  assign f_last = &cnt;
  assign f_done = (st == S_FILL) && mem_ack && f_last;

  assign s_idx  = cfg_split ? {1'b0, snoop_line[SAW-2-OW:0]} : snoop_line[SAW-1-OW:0];
  assign s_tag  = snoop_line[AW-OW-1:SAW-1-OW];
  assign s_hit  = snoop_valid && vld[s_idx] && (tags[s_idx] == s_tag);
  assign s_fill = snoop_valid && (s_tag == f_tag) && (s_idx == f_idx);

  assign miss_go = (st == S_IDLE) && cpu_req && !c_loc && !cpu_we && !cpu_nc && !c_hit;

  always_comb begin
    nxt        = st;
    cpu_wait   = cpu_req;
    cpu_rdata  = sram_rdata;
    sram_we    = 1'b0;
    sram_addr  = {c_idx, cpu_addr[OW-1:0]};
    sram_wdata = cpu_wdata;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cpu_addr;
    mem_wdata  = cpu_wdata;
    unique case (st)
      S_IDLE: if (cpu_req) begin
        if (c_loc) begin
          cpu_wait  = 1'b0;
          sram_addr = {1'b1, cpu_addr[SAW-2:0]};
          sram_we   = cpu_we && c_lwok;
        end else if (cpu_we) begin
          nxt     = S_MWR;
          sram_we = !cpu_nc && c_hit;
        end else if (cpu_nc) begin
          nxt = S_MRD;
        end else if (c_hit) begin
          cpu_wait = 1'b0;
        end else begin
          nxt = S_FILL;
        end
      end
      S_FILL: begin
        mem_req    = 1'b1;
        mem_addr   = {fa[AW-1:OW], f_off};
        sram_addr  = {f_idx, f_off};
        sram_wdata = mem_rdata;
        if (mem_ack) begin
          sram_we = 1'b1;
          if (cnt == '0) begin
            cpu_wait  = 1'b0;
            cpu_rdata = mem_rdata;
          end
          if (f_last) nxt = S_IDLE;
        end
      end
      S_MRD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cpu_wait  = 1'b0;
          cpu_rdata = mem_rdata;
          nxt       = S_IDLE;
        end
      end
      default: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_wait = 1'b0;
          nxt      = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      fa   <= '0;
      kill <= 1'b0;
      vld  <= '0;
    end else begin
      st <= nxt;
      if (miss_go) begin
        fa   <= cpu_addr;
        cnt  <= '0;
        kill <= 1'b0;
      end else if (st == S_FILL) begin
        if (mem_ack) cnt <= cnt + 1'b1;
        if (s_fill || flush) kill <= 1'b1;
      end
      if (flush) begin
        vld <= '0;
      end else begin
        if (s_hit) vld[s_idx] <= 1'b0;
        if (miss_go) vld[c_idx] <= 1'b0;
        if (f_done && !kill && !s_fill) vld[f_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (f_done) tags[f_idx] <= f_tag;
  end

  a_r2_critical_first: assert property (@(posedge clk) disable iff (!rst_n)
    miss_go |=> mem_req && !mem_we && (mem_addr == $past(cpu_addr)));

  a_r3_line_installed: assert property (@(posedge clk) disable iff (!rst_n)
    (f_done && !kill && !s_fill && !flush) |=> vld[$past(f_idx)]);

  a_r4_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_req && cpu_we && !c_loc) |=> mem_req && mem_we);

  a_r6_snoop_drop: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit |=> !vld[$past(s_idx)]);

  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  a_r8_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_req && c_loc) |=> !mem_req);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: tb/l2_split_ctrl_test.sv
`timescale 1ns/1ps
module l2_split_ctrl_test;
  localparam int MLAT = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_split = 1'b0, cfg_lro = 1'b0, shadow_load = 1'b0, flush = 1'b0;
  logic [10:0] cfg_lbase = 11'h7F0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_nc = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_wait, sram_we, mem_req, mem_we, mem_ack;
  logic [5:0] sram_addr;
  logic [31:0] sram_wdata, sram_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic snoop_valid = 1'b0;
  logic [13:0] snoop_line = '0;

  logic [31:0] sram [0:63];
  logic [31:0] mm [0:65535];
  int dly = 0, traffic = 0, r11_bad = 0;
  logic [15:0] flog [$];
  logic hold_p = 1'b0;
  logic [15:0] addr_p = '0;

  bit m_v [0:15];
  logic [10:0] m_t [0:15];
  logic [31:0] m_d [0:63];
  logic [31:0] m_ls [0:31];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  l2_split_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_lbase(cfg_lbase),
    .cfg_lro(cfg_lro), .shadow_load(shadow_load), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nc(cpu_nc), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .snoop_valid(snoop_valid), .snoop_line(snoop_line));

  assign sram_rdata = sram[sram_addr];
  assign mem_rdata  = mm[mem_addr];
  assign mem_ack    = mem_req && (dly == MLAT);

  always @(posedge clk) begin
    if (sram_we) sram[sram_addr] <= sram_wdata;
    if (mem_req && mem_ack) begin
      traffic = traffic + 1;
      flog.push_back(mem_addr);
      if (mem_we) mm[mem_addr] <= mem_wdata;
    end
    if (mem_req && !mem_ack) dly <= dly + 1; else dly <= 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (hold_p && (!mem_req || mem_addr != addr_p)) r11_bad++;
    hold_p <= mem_req && !mem_ack;
    addr_p <= mem_addr;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_idx(logic [15:0] a);
    return cfg_split ? int'(a[4:2]) : int'(a[5:2]);
  endfunction

  task automatic m_snoop(logic [15:0] a);
    int i = m_idx(a);
    if (m_v[i] && m_t[i] == a[15:5]) m_v[i] = 0;
  endtask

  task automatic m_flush();
    for (int i = 0; i < 16; i++) m_v[i] = 0;
  endtask

  task automatic run(bit we, bit nc, logic [15:0] a, logic [31:0] d, string tag, bit mid_snp = 0);
    logic [31:0] er = '0, got = '0;
    int ew = 0, et = 0, w = 0;
    int i = m_idx(a);
    bit loc = cfg_split && (a[15:5] == cfg_lbase);
    bit hit = m_v[i] && (m_t[i] == a[15:5]);
    if (loc) begin
      if (we) begin
        if (!cfg_lro || shadow_load) m_ls[a[4:0]] = d;
      end else er = m_ls[a[4:0]];
    end else if (we) begin
      ew = 1 + MLAT; et = 1;
      if (!nc && hit) m_d[i*4 + int'(a[1:0])] = d;
    end else if (nc) begin
      ew = 1 + MLAT; et = 1; er = mm[a];
    end else if (hit) begin
      er = m_d[i*4 + int'(a[1:0])];
    end else begin
      ew = 1 + MLAT; et = 4; er = mm[a];
      for (int k = 0; k < 4; k++) m_d[i*4 + k] = mm[{a[15:2], 2'(k)}];
      m_v[i] = 1; m_t[i] = a[15:5];
    end
    @(negedge clk);
    traffic = 0; flog.delete();
    cpu_req = 1; cpu_we = we; cpu_nc = nc; cpu_addr = a; cpu_wdata = d;
    forever begin
      #1;
      if (!cpu_wait) begin got = cpu_rdata; break; end
      w++;
      if (w > 50) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_nc = 0;
    if (mid_snp) begin
      snoop_valid = 1; snoop_line = a[15:2]; m_snoop(a);
      @(negedge clk);
      snoop_valid = 0;
    end
    repeat (10) @(negedge clk);
    if (!we) chk(got == er, tag, "read data", got, er);
    chk(w == ew, tag, "wait cycles", w, ew);
    chk(traffic == et, tag, "memory words", traffic, et);
  endtask

  task automatic snoop_idle(logic [15:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_line = a[15:2]; m_snoop(a);
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1; m_flush();
    @(negedge clk); flush = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 65536; i++) mm[i] = {16'hC0DE, 16'(i)};
    for (int i = 0; i < 64; i++) begin sram[i] = '0; m_d[i] = '0; end
    for (int i = 0; i < 32; i++) m_ls[i] = '0;
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_wait && !mem_req, "R7", "idle after reset", {cpu_wait, mem_req}, 0);

    // R2 wrapped fill starting at the critical word; R7 first access misses
    run(0, 0, 16'h0102, 0, "R2");
    chk(flog.size() == 4, "R2", "fill words", flog.size(), 4);
    if (flog.size() == 4) begin
      chk(flog[0] == 16'h0102, "R2", "fill word 0", flog[0], 16'h0102);
      chk(flog[1] == 16'h0103, "R2", "fill word 1", flog[1], 16'h0103);
      chk(flog[2] == 16'h0100, "R2", "fill word 2", flog[2], 16'h0100);
      chk(flog[3] == 16'h0101, "R2", "fill word 3", flog[3], 16'h0101);
    end
    run(0, 0, 16'h0100, 0, "R3");
    // R1 hit served by SRAM: stale copy after unsnooped external write
    mm[16'h0101] = 32'h1111_2222;
    run(0, 0, 16'h0101, 0, "R1");
    // R6 snoop invalidates
    snoop_idle(16'h0101);
    run(0, 0, 16'h0101, 0, "R6");
    // R4 write hit
    run(1, 0, 16'h0100, 32'hABCD_0001, "R4");
    run(0, 0, 16'h0100, 0, "R4");
    run(0, 1, 16'h0100, 0, "R4");
    // R5 write miss
    run(1, 0, 16'h0200, 32'h5555_0200, "R5");
    run(0, 0, 16'h0200, 0, "R5");
    // R10 uncacheable
    mm[16'h0100] = 32'h7777_0100;
    run(0, 1, 16'h0100, 0, "R10");
    run(1, 1, 16'h0102, 32'h9999_0102, "R10");
    run(0, 0, 16'h0102, 0, "R10");
    // R1 distinct index in full mode
    run(0, 0, 16'h0120, 0, "R1");
    run(0, 0, 16'h0100, 0, "R1");
    // R7 flush
    do_flush();
    run(0, 0, 16'h0100, 0, "R7");
    // R8 split mode aliasing
    @(negedge clk); cfg_split = 1;
    do_flush();
    run(0, 0, 16'h0100, 0, "R8");
    run(0, 0, 16'h0120, 0, "R8");
    run(0, 0, 16'h0100, 0, "R8");
    run(1, 0, 16'hFE05, 32'hFEED_0005, "R8");
    run(0, 0, 16'hFE05, 0, "R8");
    run(0, 0, 16'h0101, 0, "R8");
    // R9 read-only window
    @(negedge clk); cfg_lro = 1;
    run(1, 0, 16'hFE05, 32'hBAD0_0005, "R9");
    run(0, 0, 16'hFE05, 0, "R9");
    @(negedge clk); shadow_load = 1;
    run(1, 0, 16'hFE05, 32'h600D_0005, "R9");
    @(negedge clk); shadow_load = 0;
    run(0, 0, 16'hFE05, 0, "R9");
    // R6 snoop during an active fill blocks install
    run(0, 0, 16'h0300, 0, "R6", 1);
    run(0, 0, 16'h0300, 0, "R6");
    run(0, 0, 16'h0301, 0, "R3");

    chk(r11_bad == 0, "R11", "request held until ack", r11_bad, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule